// File: doc/BRIEF.md
# Microcode Bank Lock Controller

This block sits in front of a banked dual-port RAM that can hold downloadable microcode for an embedded controller. The address space is cut into 2 KB banks: six general banks from 0x0000 to 0x2FFF, two data banks from 0x3000 to 0x3FFF, and four banks from 0x4000 to 0x5FFF that only ever hold microcode. A 4-bit lock field chooses which banks are reserved for instruction fetch. It also fixes where the controller starts fetching after reset and whether execution begins in ROM.

The block has two RAM ports. The instruction-fetch port has its own path and can read any mapped bank every clock, whatever the data port is doing. The data port is shared by load/store, bus-slave and DMA masters, and each access on it is either passed to the RAM or blocked. A blocked write leaves the RAM untouched. A blocked read returns zero. In both cases a one-cycle flag is raised.

The RAM array is a behavioural model. Each bank stores 2^STORE_AW words, indexed by byte address bits [STORE_AW+1:2]. The remaining in-bank offset bits alias onto those words.

Top module: `mcl_lock_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are as follows: `cfg_val` = 0, `cfg_err` = 0, `boot_from_rom` = 1, `boot_addr` = 0, `data_blocked` = 0, `data_rdata` = 0 and `fetch_data` = 0.
- R2: A write to the lock field takes effect on `cfg_val` one cycle later only in two cases: the field currently holds 0000, or the written value is 0000. Any other write is ignored and the field keeps its value.
- R3: The values 0010, 0100, 0110, 1000, 1010 and 1100 lock the first value/2 general banks, counted upward from 0x0000 in 2 KB steps. They also lock all four microcode banks. They give `boot_addr` = 0x0000 and `boot_from_rom` = 0.
- R4: The values 0011, 0101, 0111 and 1001 lock value/2 microcode banks counted upward from 0x4000 and no general bank. They give `boot_addr` = 0x4000 and `boot_from_rom` = 0.
- R5: The values 0001, 1011, 1101, 1110 and 1111 are reserved. They set `cfg_err` = 1 and otherwise act like 0000: no general bank is locked, `boot_from_rom` = 1 and `boot_addr` = 0.
- R6: A data-port write to a locked bank leaves the stored word unchanged, as seen later through the fetch port or after unlocking.
- R7: A data-port read of a locked bank returns `data_rdata` = 0 one cycle after the request, with `data_blocked` = 1 in that same cycle.
- R8: Data-port accesses to 0x4000 to 0x5FFF and to the unmapped space at 0x6000 and above are always blocked, whatever the field value.
- R9: Data-port accesses to unlocked banks, and always to 0x3000 to 0x3FFF, pass through. A write is stored at the clock edge of the request, a read returns the word one cycle later, and `data_blocked` stays 0.
- R10: A fetch request returns the addressed word on `fetch_data` one cycle later, whether or not the bank is locked and even when a data access is made in the same cycle. An unmapped fetch address returns 0.
- R11: `data_blocked` is high only in the cycle after a blocked data request and falls again when no blocked request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the lock field |
| cfg_wr_val | input | 4 | Value to write into the lock field |
| cfg_val | output | 4 | Current lock field |
| cfg_err | output | 1 | Lock field holds a reserved value |
| boot_addr | output | 15 | Fetch start address after reset |
| boot_from_rom | output | 1 | Execution starts in ROM |
| fetch_en | input | 1 | Instruction fetch request |
| fetch_addr | input | 15 | Fetch byte address |
| fetch_data | output | 32 | Fetched word, one cycle after request |
| data_req | input | 1 | Data-port access request |
| data_we | input | 1 | Data-port access is a write |
| data_addr | input | 15 | Data-port byte address |
| data_wdata | input | 32 | Data-port write word |
| data_rdata | output | 32 | Data-port read word, one cycle after request |
| data_blocked | output | 1 | One-cycle pulse after a blocked access |

## Verification
A lock-field write shows on `cfg_val`, `cfg_err`, `boot_addr` and `boot_from_rom` one cycle later, because the only register on that path is the field itself. Data reads, the blocked pulse and fetch results each pass through one output register and are due in the cycle after the request. A data write commits at the request edge. The bench drives each stimulus right after a falling edge and samples at the next falling edge, which is exactly one rising edge later. For the one-cycle pulse of R11 it takes a second sample one edge further on.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    localparam int CFG_W        = 4;
    localparam int BANK_SHIFT   = 11;
    localparam int LOW_BANKS    = 6;
    localparam int UC_FIRST     = 8;
    localparam int UC_BANKS     = 4;
    localparam int MAPPED_BANKS = UC_FIRST + UC_BANKS;

    typedef enum logic [1:0] {
        MK_ROM     = 2'd0,
        MK_LOW_UC  = 2'd1,
        MK_UC_ONLY = 2'd2,
        MK_BAD     = 2'd3
    } mode_kind_e;

    typedef struct packed {
        mode_kind_e kind;
        logic [2:0] low_cnt;
        logic [2:0] uc_cnt;
    } mode_info_t;

    typedef struct packed {
        logic pass_wr;
        logic pass_rd;
        logic deny;
    } gate_t;

    function automatic mode_info_t decode_mode(input logic [CFG_W-1:0] v);
        mode_info_t m;
        m.kind    = MK_BAD;
        m.low_cnt = '0;
        m.uc_cnt  = '0;
        unique case (v)
            4'b0000: m.kind = MK_ROM;
            4'b0010, 4'b0100, 4'b0110, 4'b1000, 4'b1010, 4'b1100: begin
                m.kind    = MK_LOW_UC;
                m.low_cnt = v[3:1];
                m.uc_cnt  = 3'(UC_BANKS);
            end
            4'b0011, 4'b0101, 4'b0111, 4'b1001: begin
                m.kind   = MK_UC_ONLY;
                m.uc_cnt = v[3:1];
            end
            default: m.kind = MK_BAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mcl_cfg_reg.sv
module mcl_cfg_reg
    import mcl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_val,
    output logic [CFG_W-1:0] cfg_q
);

    logic accept;

    // A non-zero field must be cleared before taking a new non-zero value.
    assign accept = wr_en && ((cfg_q == '0) || (wr_val == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= wr_val;
        end
    end

endmodule

// File: rtl/mcl_mode_decode.sv
module mcl_mode_decode
    import mcl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int NUM_BANKS = 16
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [NUM_BANKS-1:0] lock_mask,
    output logic [ADDR_W-1:0] boot_addr,
    output logic              boot_from_rom,
    output logic              cfg_err
);

    localparam logic [ADDR_W-1:0] UC_BASE = ADDR_W'(UC_FIRST << BANK_SHIFT);

    mode_info_t info;

    assign info = decode_mode(cfg);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lock
        if (b < LOW_BANKS) begin : g_low
            assign lock_mask[b] = (int'(info.low_cnt) > b);
        end else if ((b >= UC_FIRST) && (b < UC_FIRST + UC_BANKS)) begin : g_uc
            assign lock_mask[b] = (int'(info.uc_cnt) > (b - UC_FIRST));
        end else begin : g_free
            assign lock_mask[b] = 1'b0;
        end
    end

    always_comb begin
        boot_addr     = '0;
        boot_from_rom = 1'b0;
        cfg_err       = 1'b0;
        unique case (info.kind)
            MK_ROM:     boot_from_rom = 1'b1;
            MK_LOW_UC:  boot_addr     = '0;
            MK_UC_ONLY: boot_addr     = UC_BASE;
            MK_BAD: begin
                boot_from_rom = 1'b1;
                cfg_err       = 1'b1;
            end
            default: boot_from_rom = 1'b1;
        endcase
    end

endmodule

// File: rtl/mcl_access_gate.sv
module mcl_access_gate
    import mcl_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int BANK_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 we,
    input  logic [BANK_W-1:0]    bank,
    input  logic [NUM_BANKS-1:0] lock_mask,
    output gate_t                gate,
    output logic                 blocked_q
);

    logic [NUM_BANKS-1:0] usable;
    logic                 open_bank;

    // Only banks below the microcode region are ever reachable for data.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_use
        if ((b < UC_FIRST) && (b < MAPPED_BANKS)) begin : g_dat
            assign usable[b] = ~lock_mask[b];
        end else begin : g_never
            assign usable[b] = 1'b0;
        end
    end

    assign open_bank    = usable[bank];
    assign gate.pass_wr = req &  we & open_bank;
    assign gate.pass_rd = req & ~we & open_bank;
    assign gate.deny    = req & ~open_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked_q <= 1'b0;
        end else begin
            blocked_q <= gate.deny;
        end
    end

endmodule

// File: rtl/mcl_bank_ram.sv
module mcl_bank_ram
    import mcl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BANK_W   = 4,
    parameter int WORD_AW  = 5,
    parameter int MAPPED   = MAPPED_BANKS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [BANK_W-1:0]  d_bank,
    input  logic [WORD_AW-1:0] d_word,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               f_en,
    input  logic [BANK_W-1:0]  f_bank,
    input  logic [WORD_AW-1:0] f_word,
    output logic [DATA_W-1:0]  f_data
);

    localparam int WORDS = 1 << WORD_AW;

    logic [DATA_W-1:0] bank_rd [MAPPED];
    logic [DATA_W-1:0] bank_f  [MAPPED];
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] f_sel;
    logic              f_hit;

    for (genvar b = 0; b < MAPPED; b++) begin : g_bank
        logic [DATA_W-1:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && (d_bank == BANK_W'(b))) begin
                mem[d_word] <= wdata;
            end
        end

        assign bank_rd[b] = mem[d_word];
        assign bank_f[b]  = mem[f_word];
    end

    always_comb begin
        rd_sel = '0;
        f_sel  = '0;
        for (int b = 0; b < MAPPED; b++) begin
            if (d_bank == BANK_W'(b)) rd_sel = bank_rd[b];
            if (f_bank == BANK_W'(b)) f_sel  = bank_f[b];
        end
    end

    assign f_hit = (int'(f_bank) < MAPPED);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            f_data  <= '0;
        end else begin
            rd_data <= rd_en ? rd_sel : '0;
            f_data  <= (f_en && f_hit) ? f_sel : '0;
        end
    end

endmodule

// File: rtl/mcl_lock_ctrl.sv
module mcl_lock_ctrl
    import mcl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 32,
    parameter int STORE_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_val,
    output logic [CFG_W-1:0]  cfg_val,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] boot_addr,
    output logic              boot_from_rom,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data,
    input  logic              data_req,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              data_blocked
);

    localparam int BANK_W    = ADDR_W - BANK_SHIFT;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int WORD_LSB  = 2;

    logic [NUM_BANKS-1:0] lock_mask;
    gate_t                gate;
    logic [BANK_W-1:0]    d_bank;
    logic [BANK_W-1:0]    f_bank;
    logic [STORE_AW-1:0]  d_word;
    logic [STORE_AW-1:0]  f_word;

    assign d_bank = data_addr[ADDR_W-1:BANK_SHIFT];
    assign f_bank = fetch_addr[ADDR_W-1:BANK_SHIFT];
    assign d_word = data_addr[WORD_LSB +: STORE_AW];
    assign f_word = fetch_addr[WORD_LSB +: STORE_AW];

    mcl_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr_en),
        .wr_val (cfg_wr_val),
        .cfg_q  (cfg_val)
    );

    mcl_mode_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .cfg           (cfg_val),
        .lock_mask     (lock_mask),
        .boot_addr     (boot_addr),
        .boot_from_rom (boot_from_rom),
        .cfg_err       (cfg_err)
    );

    mcl_access_gate #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .req       (data_req),
        .we        (data_we),
        .bank      (d_bank),
        .lock_mask (lock_mask),
        .gate      (gate),
        .blocked_q (data_blocked)
    );

    mcl_bank_ram #(
        .DATA_W  (DATA_W),
        .BANK_W  (BANK_W),
        .WORD_AW (STORE_AW),
        .MAPPED  (MAPPED_BANKS)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (gate.pass_wr),
        .rd_en   (gate.pass_rd),
        .d_bank  (d_bank),
        .d_word  (d_word),
        .wdata   (data_wdata),
        .rd_data (data_rdata),
        .f_en    (fetch_en),
        .f_bank  (f_bank),
        .f_word  (f_word),
        .f_data  (fetch_data)
    );

endmodule

// File: rtl/mcl_lock_checker.sv
module mcl_lock_checker
    import mcl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_wr_en,
    input logic [CFG_W-1:0]     cfg_wr_val,
    input logic [CFG_W-1:0]     cfg_val,
    input logic                 cfg_err,
    input logic [ADDR_W-1:0]    boot_addr,
    input logic                 boot_from_rom,
    input logic                 data_req,
    input logic [ADDR_W-1:0]    data_addr,
    input logic [DATA_W-1:0]    data_rdata,
    input logic [DATA_W-1:0]    fetch_data,
    input logic                 data_blocked,
    input logic [NUM_BANKS-1:0] lock_mask
);

    localparam int BANK_W = ADDR_W - BANK_SHIFT;

    logic [BANK_W-1:0] bank;
    assign bank = data_addr[ADDR_W-1:BANK_SHIFT];

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cfg_val == '0 && !data_blocked && data_rdata == '0 && fetch_data == '0));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_val != '0 && !(cfg_wr_en && cfg_wr_val == '0)) |=> $stable(cfg_val));

    assert_reserved_rom_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (boot_from_rom && boot_addr == '0));

    assert_locked_denied_R7: assert property (@(posedge clk) disable iff (rst)
        (data_req && lock_mask[bank]) |=> data_blocked);

    assert_blocked_zero_R7: assert property (@(posedge clk) disable iff (rst)
        data_blocked |-> (data_rdata == '0));

    assert_high_region_R8: assert property (@(posedge clk) disable iff (rst)
        (data_req && int'(bank) >= UC_FIRST) |=> data_blocked);

    assert_data_banks_open_R9: assert property (@(posedge clk) disable iff (rst)
        (data_req && int'(bank) >= LOW_BANKS && int'(bank) < UC_FIRST) |=> !data_blocked);

    assert_pulse_source_R11: assert property (@(posedge clk) disable iff (rst)
        data_blocked |-> $past(data_req));

endmodule

bind mcl_lock_ctrl mcl_lock_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
) chk (.*);

// File: tb/mcl_lock_ctrl_test.sv
module mcl_lock_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [3:0]  cfg_wr_val;
    logic [3:0]  cfg_val;
    logic        cfg_err;
    logic [14:0] boot_addr;
    logic        boot_from_rom;
    logic        fetch_en;
    logic [14:0] fetch_addr;
    logic [31:0] fetch_data;
    logic        data_req;
    logic        data_we;
    logic [14:0] data_addr;
    logic [31:0] data_wdata;
    logic [31:0] data_rdata;
    logic        data_blocked;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mcl_lock_ctrl uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] v);
        cfg_wr_en = 1'b1; cfg_wr_val = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic dwrite(input logic [14:0] a, input logic [31:0] d, output logic blk);
        data_req = 1'b1; data_we = 1'b1; data_addr = a; data_wdata = d;
        @(negedge clk);
        data_req = 1'b0; data_we = 1'b0;
        blk = data_blocked;
    endtask

    task automatic dread(input string tag, input logic [14:0] a,
                         input logic [31:0] exp, input logic exp_blk);
        data_req = 1'b1; data_we = 1'b0; data_addr = a;
        @(negedge clk);
        data_req = 1'b0;
        chk({tag, " rdata"}, data_rdata, exp);
        chk({tag, " blocked"}, 32'(data_blocked), 32'(exp_blk));
    endtask

    task automatic fread(input string tag, input logic [14:0] a, input logic [31:0] exp);
        fetch_en = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_en = 1'b0;
        chk(tag, fetch_data, exp);
    endtask

    task automatic check_boot(input string tag, input logic [3:0] c, input logic err,
                              input logic rom, input logic [14:0] ba);
        chk({tag, " cfg"}, 32'(cfg_val), 32'(c));
        chk({tag, " err"}, 32'(cfg_err), 32'(err));
        chk({tag, " rom"}, 32'(boot_from_rom), 32'(rom));
        chk({tag, " boot"}, 32'(boot_addr), 32'(ba));
    endtask

    task automatic t_reset;
        chk("R1 fetch_data", fetch_data, 32'h0);
        chk("R1 rdata", data_rdata, 32'h0);
        chk("R1 blocked", 32'(data_blocked), 32'h0);
        check_boot("R1", 4'h0, 1'b0, 1'b1, 15'h0);
    endtask

    task automatic t_open;
        logic blk;
        dwrite(15'h0004, 32'hA1A1_0001, blk); chk("R9 wr bank0", 32'(blk), 0);
        dwrite(15'h0804, 32'hB2B2_0002, blk); chk("R9 wr bank1", 32'(blk), 0);
        dwrite(15'h2808, 32'hC3C3_0003, blk); chk("R9 wr bank5", 32'(blk), 0);
        dwrite(15'h3000, 32'hD4D4_0004, blk); chk("R9 wr bank6", 32'(blk), 0);
        dwrite(15'h3804, 32'hE5E5_0005, blk); chk("R9 wr bank7", 32'(blk), 0);
        dread("R9 rd bank0", 15'h0004, 32'hA1A1_0001, 1'b0);
        dread("R9 rd bank5", 15'h2808, 32'hC3C3_0003, 1'b0);
        dread("R9 rd bank7", 15'h3804, 32'hE5E5_0005, 1'b0);
        fread("R10 fetch bank1", 15'h0804, 32'hB2B2_0002);
        // R10: fetch and data read in the same cycle
        fetch_en = 1'b1; fetch_addr = 15'h0004;
        data_req = 1'b1; data_we = 1'b0; data_addr = 15'h3000;
        @(negedge clk);
        fetch_en = 1'b0; data_req = 1'b0;
        chk("R10 concurrent fetch", fetch_data, 32'hA1A1_0001);
        chk("R10 concurrent data", data_rdata, 32'hD4D4_0004);
    endtask

    task automatic t_high_region;
        logic blk;
        dwrite(15'h4000, 32'h1234_5678, blk); chk("R8 wr 0x4000 mode0", 32'(blk), 1);
        dread("R8 rd 0x4800 mode0", 15'h4800, 32'h0, 1'b1);
        dread("R8 rd 0x6000 mode0", 15'h6000, 32'h0, 1'b1);
        fread("R10 fetch unmapped", 15'h6000, 32'h0);
    endtask

    task automatic t_lock6;
        logic blk;
        set_cfg(4'h6);
        check_boot("R3 mode6", 4'h6, 1'b0, 1'b0, 15'h0);
        dwrite(15'h0804, 32'hFFFF_FFFF, blk); chk("R6 wr locked blocked", 32'(blk), 1);
        dread("R7 rd locked", 15'h0804, 32'h0, 1'b1);
        @(negedge clk);
        chk("R11 pulse falls", 32'(data_blocked), 0);
        fread("R6 content kept", 15'h0804, 32'hB2B2_0002);
        dread("R3 bank5 open in mode6", 15'h2808, 32'hC3C3_0003, 1'b0);
        dread("R9 bank6 open in mode6", 15'h3000, 32'hD4D4_0004, 1'b0);
        dwrite(15'h4800, 32'h0, blk); chk("R8 wr ucode mode6", 32'(blk), 1);
    endtask

    task automatic t_cfg_rule;
        set_cfg(4'h2);
        chk("R2 non-zero over non-zero ignored", 32'(cfg_val), 32'h6);
        set_cfg(4'h0);
        chk("R2 clear accepted", 32'(cfg_val), 32'h0);
        dread("R6 content after unlock", 15'h0804, 32'hB2B2_0002, 1'b0);
    endtask

    task automatic t_lock_sizes;
        set_cfg(4'hC);
        check_boot("R3 modeC", 4'hC, 1'b0, 1'b0, 15'h0);
        dread("R3 bank5 locked modeC", 15'h2808, 32'h0, 1'b1);
        dread("R9 bank7 open modeC", 15'h3804, 32'hE5E5_0005, 1'b0);
        set_cfg(4'h0);
        set_cfg(4'h2);
        dread("R3 bank0 locked mode2", 15'h0004, 32'h0, 1'b1);
        dread("R3 bank1 open mode2", 15'h0804, 32'hB2B2_0002, 1'b0);
        set_cfg(4'h0);
    endtask

    task automatic t_uc_only;
        logic blk;
        set_cfg(4'h9);
        check_boot("R4 mode9", 4'h9, 1'b0, 1'b0, 15'h4000);
        dread("R4 bank0 open mode9", 15'h0004, 32'hA1A1_0001, 1'b0);
        dread("R4 bank5 open mode9", 15'h2808, 32'hC3C3_0003, 1'b0);
        dwrite(15'h5800, 32'h5555_5555, blk); chk("R8 wr 0x5800 mode9", 32'(blk), 1);
        set_cfg(4'h0);
        set_cfg(4'h3);
        check_boot("R4 mode3", 4'h3, 1'b0, 1'b0, 15'h4000);
        set_cfg(4'h0);
        check_boot("R1 back to rom", 4'h0, 1'b0, 1'b1, 15'h0);
    endtask

    task automatic t_reserved;
        set_cfg(4'hE);
        check_boot("R5 modeE", 4'hE, 1'b1, 1'b1, 15'h0);
        dread("R5 bank0 open modeE", 15'h0004, 32'hA1A1_0001, 1'b0);
        set_cfg(4'h4);
        chk("R2 write over reserved ignored", 32'(cfg_val), 32'hE);
        set_cfg(4'h0);
        chk("R5 err clears", 32'(cfg_err), 0);
        set_cfg(4'h1);
        check_boot("R5 mode1", 4'h1, 1'b1, 1'b1, 15'h0);
        set_cfg(4'h0);
    endtask

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_val = '0;
        fetch_en = 1'b0; fetch_addr = '0;
        data_req = 1'b0; data_we = 1'b0; data_addr = '0; data_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_open;
        t_high_region;
        t_lock6;
        t_cfg_rule;
        t_lock_sizes;
        t_uc_only;
        t_reserved;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule